// File: doc/BRIEF.md
# Remote Framebuffer Command and Data Engine

This block lets a host drive up to two external smart display controllers over a 16-bit parallel bus. The host writes a command, a parameter or a pixel data word into a register, and the engine turns the access into one or two 16-bit bus cycles. Each cycle carries a flag that tells the controller whether the word is a command (flag low) or data (flag high). The cycle goes to every chip that is selected in the control register. The host can also start a read cycle, and the sampled word is kept in a receive buffer.

A down-counting pixel counter tracks a programmed transfer. The host loads the count, then sets the trigger bit in the control register. If the engine is enabled, idle and the configuration condition holds, the engine becomes busy. Each data write or read access decrements the count. When the count reaches zero during a triggered transfer, busy clears and a one-clock frame-done pulse is raised.

Every bus cycle has a fixed shape: select and strobe for two clocks, then one idle clock. While cycles are queued, `host_ready` is low and the host must hold its write until it rises. The timing and format registers are stored only and do not affect the bus.

Top module: `rfb_engine`

## Requirements
- R1: After reset the control register reads 0, the pixel count reads 0, both configuration registers read 0x00310000, and the status register (index 0) reads 0x00000001.
- R2: Write masks. The control register (index 1) keeps bits 3:0. The configuration registers (indices 9 and 10) keep mask 0x003F1FFF. The line register (index 3) keeps 11 bits. The six format registers (indices 11 to 16) keep mask 0x0F1F0F1F. The pixel count (index 2) keeps all 32 bits.
- R3: A write to the command register (index 4) produces one bus cycle with `bus_dc` low and `bus_dout` equal to write bits 15:0. A write to the parameter register (index 5) produces the same cycle with `bus_dc` high.
- R4: A write to the data register (index 6) produces two bus cycles with `bus_dc` high: bits 15:0 first, then bits 31:16.
- R5: `bus_cs` bit 0 selects chip 0 and follows control bit 2; `bus_cs` bit 1 selects chip 1 and follows control bit 3. A write cycle asserts every selected chip at once. With no chip selected, no bus cycle occurs and the host is not stalled.
- R6: Each bus cycle holds select and strobe for exactly 2 clocks, followed by 1 idle clock. `host_ready` stays low from the accepting clock until the last idle clock has passed: 3 clocks for one cycle, 6 for two.
- R7: A write to index 7 starts a read cycle with `bus_dc` high, and a write to index 8 starts one with `bus_dc` low. The cycle asserts `bus_rd` on chip 0 if chip 0 is selected, otherwise on chip 1. The value of `bus_din` on the last strobe clock is latched, and indices 7 and 8 read it back.
- R8: The pixel count decrements by one on each accepted write to index 6, 7 or 8, whether or not a chip is selected. Command and parameter writes leave it unchanged.
- R9: A control write with bit 4 set makes the engine busy only if three conditions hold: the written bit 0 is 1, the engine is not busy, and (config0 AND config1 AND 0xC) equals 0. Busy reads as bit 8 of the status register.
- R10: When the count decrements to zero while busy, busy clears and `frame_done` goes high for exactly one clock. Reaching zero while not busy raises no pulse.
- R11: Writes to the status register are ignored, and its bit 0 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write request, held until accepted |
| host_addr | input | 5 | Register index for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for `host_addr` (combinational) |
| host_ready | output | 1 | High when a write is accepted on this clock |
| bus_cs | output | 2 | Chip selects, bit 0 = chip 0 |
| bus_we | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_dc | output | 1 | 0 = command cycle, 1 = data cycle |
| bus_dout | output | 16 | Word driven to the controllers |
| bus_din | input | 16 | Word returned by the selected controller |
| frame_done | output | 1 | One-clock pulse when a triggered transfer completes |

## Verification
The assertions assume that the host writes only while `host_ready` is high. They also assume that `bus_din` is valid whenever a read strobe is active. The stimulus holds each write until ready rises and drives nothing else until the stall clears. The bench's bus model returns a distinct word for each chip, derived from the current select, so a wrong chip choice shows up as a wrong value.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    localparam int NUM_CS     = 2;
    localparam int CS_LSB     = 2;
    localparam int CTRL_W     = 4;
    localparam int LINE_W     = 11;
    localparam int NUM_FMT    = 6;
    localparam int TRIG_BIT   = 4;
    localparam logic [31:0] CFG_RESET = 32'h0031_0000;
    localparam logic [31:0] CFG_MASK  = 32'h003F_1FFF;
    localparam logic [31:0] FMT_MASK  = 32'h0F1F_0F1F;
    localparam logic [31:0] COND_MASK = 32'h0000_000C;

    // register index map
    localparam logic [4:0] IX_STATUS = 5'd0;
    localparam logic [4:0] IX_CTRL   = 5'd1;
    localparam logic [4:0] IX_COUNT  = 5'd2;
    localparam logic [4:0] IX_LINE   = 5'd3;
    localparam logic [4:0] IX_CMD    = 5'd4;
    localparam logic [4:0] IX_PARAM  = 5'd5;
    localparam logic [4:0] IX_DATA   = 5'd6;
    localparam logic [4:0] IX_RDDAT  = 5'd7;
    localparam logic [4:0] IX_RDSTS  = 5'd8;
    localparam logic [4:0] IX_CFG0   = 5'd9;
    localparam logic [4:0] IX_CFG1   = 5'd10;
    localparam logic [4:0] IX_FMT0   = 5'd11;

    typedef enum logic [2:0] {
        XF_NONE, XF_CMD, XF_PARAM, XF_DATA, XF_RDDAT, XF_RDSTS
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e         kind;
        logic [31:0]        word;
        logic [NUM_CS-1:0]  cs;
    } xfer_req_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_STROBE, SQ_GAP} seq_state_e;

    function automatic xfer_kind_e kind_of(input logic [4:0] ix);
        case (ix)
            IX_CMD:   return XF_CMD;
            IX_PARAM: return XF_PARAM;
            IX_DATA:  return XF_DATA;
            IX_RDDAT: return XF_RDDAT;
            IX_RDSTS: return XF_RDSTS;
            default:  return XF_NONE;
        endcase
    endfunction

    function automatic logic is_read(input xfer_kind_e k);
        return (k == XF_RDDAT) || (k == XF_RDSTS);
    endfunction

    function automatic logic counts_pixel(input xfer_kind_e k);
        return (k == XF_DATA) || is_read(k);
    endfunction

    // data flag: low for command and status-read cycles
    function automatic logic data_flag(input xfer_kind_e k);
        return (k != XF_CMD) && (k != XF_RDSTS);
    endfunction

    // reads go to the lowest selected chip only
    function automatic logic [NUM_CS-1:0] read_pick(input logic [NUM_CS-1:0] sel);
        logic [NUM_CS-1:0] r;
        r = '0;
        for (int i = NUM_CS - 1; i >= 0; i--)
            if (sel[i]) r = NUM_CS'(1) << i;
        return r;
    endfunction

endpackage

// File: rtl/rfb_pixctr.sv
module rfb_pixctr
    import rfb_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PIX_W-1:0] load_val,
    input  logic             dec,
    input  logic             trig,
    input  logic             en_new,
    input  logic             cfg_ok,
    output logic [PIX_W-1:0] count,
    output logic             busy,
    output logic             frame_done
);

    logic start;
    assign start = trig && en_new && !busy && cfg_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            busy       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (load) begin
                count <= load_val;
            end else if (dec) begin
                count <= count - PIX_W'(1);
                if (count == PIX_W'(1) && busy) begin
                    busy       <= 1'b0;
                    frame_done <= 1'b1;
                end
            end
            if (start)
                busy <= 1'b1;
        end
    end

endmodule

// File: rtl/rfb_seq.sv
module rfb_seq
    import rfb_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int GAP_CLKS    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         req,
    input  logic [15:0]       bus_din,
    output logic              ready,
    output logic [NUM_CS-1:0] bus_cs,
    output logic              bus_we,
    output logic              bus_rd,
    output logic              bus_dc,
    output logic [15:0]       bus_dout,
    output logic              rx_valid,
    output logic [15:0]       rx_data
);

    localparam int TICK_MAX = (STROBE_CLKS > GAP_CLKS) ? STROBE_CLKS : GAP_CLKS;
    localparam int TICK_W   = $clog2(TICK_MAX + 1);
    localparam logic [TICK_W-1:0] STROBE_LAST = TICK_W'(STROBE_CLKS - 1);
    localparam logic [TICK_W-1:0] GAP_LAST    = TICK_W'(GAP_CLKS - 1);

    seq_state_e        state;
    logic [TICK_W-1:0] tick;
    logic [NUM_CS-1:0] cs_hold;
    logic              rd_hold;
    logic              dc_hold;
    logic [15:0]       word_now;
    logic [15:0]       word_hi;
    logic              hi_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            tick       <= '0;
            cs_hold    <= '0;
            rd_hold    <= 1'b0;
            dc_hold    <= 1'b0;
            word_now   <= '0;
            word_hi    <= '0;
            hi_pending <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state      <= SQ_STROBE;
                        tick       <= '0;
                        rd_hold    <= is_read(req.kind);
                        dc_hold    <= data_flag(req.kind);
                        cs_hold    <= is_read(req.kind) ? read_pick(req.cs) : req.cs;
                        word_now   <= req.word[15:0];
                        word_hi    <= req.word[31:16];
                        hi_pending <= (req.kind == XF_DATA);
                    end
                end
                SQ_STROBE: begin
                    if (tick == STROBE_LAST) begin
                        state <= SQ_GAP;
                        tick  <= '0;
                    end else begin
                        tick <= tick + TICK_W'(1);
                    end
                end
                default: begin
                    if (tick == GAP_LAST) begin
                        tick <= '0;
                        if (hi_pending) begin
                            state      <= SQ_STROBE;
                            word_now   <= word_hi;
                            hi_pending <= 1'b0;
                        end else begin
                            state <= SQ_IDLE;
                        end
                    end else begin
                        tick <= tick + TICK_W'(1);
                    end
                end
            endcase
        end
    end

    logic strobing;
    assign strobing = (state == SQ_STROBE);
    assign ready    = (state == SQ_IDLE);
    assign bus_cs   = strobing ? cs_hold : '0;
    assign bus_we   = strobing && !rd_hold;
    assign bus_rd   = strobing && rd_hold;
    assign bus_dc   = strobing && dc_hold;
    assign bus_dout = word_now;
    assign rx_valid = bus_rd && (tick == STROBE_LAST);
    assign rx_data  = bus_din;

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile
    import rfb_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              rx_valid,
    input  logic [15:0]       rx_data,
    input  logic [PIX_W-1:0]  count,
    input  logic              busy,
    output logic [CTRL_W-1:0] ctrl,
    output logic              cfg_ok,
    output logic [31:0]       rdata
);

    logic [LINE_W-1:0] line_q;
    logic [31:0]       cfg_q [2];
    logic [31:0]       fmt_q [NUM_FMT];
    logic [15:0]       rxbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            line_q   <= '0;
            cfg_q[0] <= CFG_RESET;
            cfg_q[1] <= CFG_RESET;
            rxbuf    <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    IX_CTRL: ctrl     <= wdata[CTRL_W-1:0];
                    IX_LINE: line_q   <= wdata[LINE_W-1:0];
                    IX_CFG0: cfg_q[0] <= wdata & CFG_MASK;
                    IX_CFG1: cfg_q[1] <= wdata & CFG_MASK;
                    default: ;
                endcase
            end
            if (rx_valid)
                rxbuf <= rx_data;
        end
    end

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        always_ff @(posedge clk) begin
            if (rst)
                fmt_q[g] <= '0;
            else if (wr_en && addr == IX_FMT0 + 5'(g))
                fmt_q[g] <= wdata & FMT_MASK;
        end
    end

    assign cfg_ok = ((cfg_q[0] & cfg_q[1] & COND_MASK) == '0);

    always_comb begin
        rdata = '0;
        case (addr)
            IX_STATUS:          rdata = {23'd0, busy, 7'd0, 1'b1};
            IX_CTRL:            rdata = 32'(ctrl);
            IX_COUNT:           rdata = 32'(count);
            IX_LINE:            rdata = 32'(line_q);
            IX_RDDAT, IX_RDSTS: rdata = {16'd0, rxbuf};
            IX_CFG0:            rdata = cfg_q[0];
            IX_CFG1:            rdata = cfg_q[1];
            default: begin
                for (int i = 0; i < NUM_FMT; i++)
                    if (addr == IX_FMT0 + 5'(i)) rdata = fmt_q[i];
            end
        endcase
    end

endmodule

// File: rtl/rfb_engine.sv
module rfb_engine
    import rfb_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int GAP_CLKS    = 1,
    parameter int PIX_W       = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [4:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_ready,
    output logic [1:0]  bus_cs,
    output logic        bus_we,
    output logic        bus_rd,
    output logic        bus_dc,
    output logic [15:0] bus_dout,
    input  logic [15:0] bus_din,
    output logic        frame_done
);

    logic              accept;
    logic [CTRL_W-1:0] ctrl;
    logic              cfg_ok;
    logic              busy;
    logic [PIX_W-1:0]  count;
    logic              rx_valid;
    logic [15:0]       rx_data;
    xfer_req_t         req;
    logic              seq_start;

    assign accept   = host_wr && host_ready;
    assign req.kind = kind_of(host_addr);
    assign req.word = host_wdata;
    assign req.cs   = ctrl[CS_LSB +: NUM_CS];
    assign seq_start = accept && (req.kind != XF_NONE) && (req.cs != '0);

    rfb_regfile #(.PIX_W(PIX_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .count    (count),
        .busy     (busy),
        .ctrl     (ctrl),
        .cfg_ok   (cfg_ok),
        .rdata    (host_rdata)
    );

    rfb_pixctr #(.PIX_W(PIX_W)) i_pix (
        .clk        (clk),
        .rst        (rst),
        .load       (accept && host_addr == IX_COUNT),
        .load_val   (host_wdata[PIX_W-1:0]),
        .dec        (accept && counts_pixel(req.kind)),
        .trig       (accept && host_addr == IX_CTRL && host_wdata[TRIG_BIT]),
        .en_new     (host_wdata[0]),
        .cfg_ok     (cfg_ok),
        .count      (count),
        .busy       (busy),
        .frame_done (frame_done)
    );

    rfb_seq #(.STROBE_CLKS(STROBE_CLKS), .GAP_CLKS(GAP_CLKS)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .req      (req),
        .bus_din  (bus_din),
        .ready    (host_ready),
        .bus_cs   (bus_cs),
        .bus_we   (bus_we),
        .bus_rd   (bus_rd),
        .bus_dc   (bus_dc),
        .bus_dout (bus_dout),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

endmodule

// File: rtl/rfb_engine_chk.sv
module rfb_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_ready,
    input logic [1:0]  bus_cs,
    input logic        bus_we,
    input logic        bus_rd,
    input logic [15:0] bus_dout,
    input logic        frame_done,
    input logic        busy
);

    assert_strobe_has_cs_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_rd) |-> (bus_cs != 2'b00));

    assert_read_one_chip_R7: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> ($countones(bus_cs) == 1));

    assert_we_rd_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_rd));

    assert_stall_during_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_rd) |-> !host_ready);

    assert_dout_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && $past(bus_we)) |-> $stable(bus_dout));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !busy);

endmodule

bind rfb_engine rfb_engine_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .host_ready (host_ready),
    .bus_cs     (bus_cs),
    .bus_we     (bus_we),
    .bus_rd     (bus_rd),
    .bus_dout   (bus_dout),
    .frame_done (frame_done),
    .busy       (busy)
);

// File: tb/test_rfb_engine.sv
module test_rfb_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic [1:0]  bus_cs;
    logic        bus_we, bus_rd, bus_dc;
    logic [15:0] bus_dout;
    logic [15:0] bus_din;
    logic        frame_done;

    logic [15:0] chip0_word = 16'h1111;
    logic [15:0] chip1_word = 16'h2222;
    assign bus_din = bus_cs[0] ? chip0_word : chip1_word;

    always #10 clk = ~clk;

    rfb_engine i_rfb_engine (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_rd(bus_rd), .bus_dc(bus_dc),
        .bus_dout(bus_dout), .bus_din(bus_din), .frame_done(frame_done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // bus monitor: one record per strobe burst
    logic [15:0] r_dout [16];
    logic        r_dc   [16];
    logic [1:0]  r_cs   [16];
    logic        r_rd   [16];
    int          r_len  [16];
    int          r_gap  [16];
    int nrec = 0, cur_len = 0, gap_run = 0, fd_cnt = 0;
    logic prev_act = 1'b0;

    always @(negedge clk) begin
        logic act;
        act = bus_we | bus_rd;
        if (frame_done) fd_cnt++;
        if (act && !prev_act) begin
            r_dout[nrec & 15] = bus_dout;
            r_dc[nrec & 15]   = bus_dc;
            r_cs[nrec & 15]   = bus_cs;
            r_rd[nrec & 15]   = bus_rd;
            r_gap[nrec & 15]  = gap_run;
            cur_len = 1;
        end else if (act) begin
            cur_len++;
        end else if (prev_act) begin
            r_len[nrec & 15] = cur_len;
            nrec++;
            gap_run = 1;
        end else begin
            gap_run++;
        end
        prev_act = act;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d, output int stall);
        while (!host_ready) @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        stall = 0;
        while (!host_ready) begin
            stall++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
        @(negedge clk);
    endtask

    // index, write value, expected readback
    localparam logic [68:0] VECS [0:10] = '{
        {5'd1,  32'hFFFF_FFEF, 32'h0000_000F},
        {5'd9,  32'hFFFF_FFFF, 32'h003F_1FFF},
        {5'd9,  32'h0031_0000, 32'h0031_0000},
        {5'd10, 32'h1234_5678, 32'h0034_1678},
        {5'd10, 32'h0031_0000, 32'h0031_0000},
        {5'd3,  32'h0000_FFFF, 32'h0000_07FF},
        {5'd11, 32'hFFFF_FFFF, 32'h0F1F_0F1F},
        {5'd16, 32'hA5A5_A5A5, 32'h0505_0505},
        {5'd2,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {5'd0,  32'hFFFF_FFFF, 32'h0000_0001},
        {5'd1,  32'h0000_0000, 32'h0000_0000}
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int st, base, fd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(5'd0, v);  chk("R1 status", v, 32'h1);
        rd(5'd1, v);  chk("R1 ctrl", v, 32'h0);
        rd(5'd2, v);  chk("R1 count", v, 32'h0);
        rd(5'd9, v);  chk("R1 cfg0", v, 32'h0031_0000);
        rd(5'd10, v); chk("R1 cfg1", v, 32'h0031_0000);

        // R2 / R11 masks and read-only status
        for (int i = 0; i < 11; i++) begin
            wr(VECS[i][68:64], VECS[i][63:32], st);
            rd(VECS[i][68:64], v);
            chk((VECS[i][68:64] == 5'd0) ? "R11 status write ignored" : "R2 mask", v, VECS[i][31:0]);
        end

        // R3 R5 R6 command to chip 0
        wr(5'd1, 32'h5, st);
        wr(5'd2, 32'd5, st);
        base = nrec;
        wr(5'd4, 32'hABCD_1234, st);
        chk("R6 stall one cycle", st, 3);
        chk("R3 one record", nrec - base, 1);
        chk("R3 cmd word", r_dout[base & 15], 32'h1234);
        chk("R3 cmd flag", r_dc[base & 15], 0);
        chk("R5 chip0 only", r_cs[base & 15], 2'b01);
        chk("R6 strobe length", r_len[base & 15], 2);
        rd(5'd2, v); chk("R8 cmd no decrement", v, 32'd5);

        // R3 R5 parameter to both chips
        wr(5'd1, 32'hD, st);
        base = nrec;
        wr(5'd5, 32'h0000_BEEF, st);
        chk("R3 param word", r_dout[base & 15], 32'hBEEF);
        chk("R3 param flag", r_dc[base & 15], 1);
        chk("R5 both chips", r_cs[base & 15], 2'b11);

        // R4 R6 R8 data to chip 1
        wr(5'd1, 32'h9, st);
        base = nrec;
        wr(5'd6, 32'h89AB_CDEF, st);
        chk("R6 stall two cycles", st, 6);
        chk("R4 two records", nrec - base, 2);
        chk("R4 low half first", r_dout[base & 15], 32'hCDEF);
        chk("R4 high half second", r_dout[(base + 1) & 15], 32'h89AB);
        chk("R4 data flag", r_dc[(base + 1) & 15], 1);
        chk("R5 chip1 only", r_cs[base & 15], 2'b10);
        chk("R6 idle gap", r_gap[(base + 1) & 15], 1);
        rd(5'd2, v); chk("R8 data decrement", v, 32'd4);

        // R5 R8 no chip selected
        wr(5'd1, 32'h1, st);
        base = nrec;
        wr(5'd6, 32'h5555_AAAA, st);
        chk("R5 no stall", st, 0);
        chk("R5 no cycle", nrec - base, 0);
        rd(5'd2, v); chk("R8 decrement without chip", v, 32'd3);

        // R7 reads
        wr(5'd1, 32'hD, st);
        base = nrec;
        wr(5'd7, 32'h0, st);
        chk("R7 read strobe", r_rd[base & 15], 1);
        chk("R7 read picks chip0", r_cs[base & 15], 2'b01);
        chk("R7 read data flag", r_dc[base & 15], 1);
        rd(5'd7, v); chk("R7 rx chip0", v, 32'h1111);
        wr(5'd1, 32'h9, st);
        base = nrec;
        wr(5'd8, 32'h0, st);
        chk("R7 status read chip1", r_cs[base & 15], 2'b10);
        chk("R7 status read flag", r_dc[base & 15], 0);
        rd(5'd8, v); chk("R7 rx chip1", v, 32'h2222);
        rd(5'd2, v); chk("R8 read decrements", v, 32'd1);

        // R9 trigger conditions
        wr(5'd9, 32'hC, st);
        wr(5'd10, 32'hC, st);
        wr(5'd1, 32'h19, st);
        rd(5'd0, v); chk("R9 config blocks trigger", v, 32'h1);
        wr(5'd10, 32'h0, st);
        wr(5'd1, 32'h18, st);
        rd(5'd0, v); chk("R9 disabled blocks trigger", v, 32'h1);
        wr(5'd1, 32'h19, st);
        rd(5'd0, v); chk("R9 trigger sets busy", v, 32'h101);

        // R10 completion
        fd0 = fd_cnt;
        wr(5'd6, 32'h0000_0001, st);
        chk("R10 one frame_done pulse", fd_cnt - fd0, 1);
        rd(5'd0, v); chk("R10 busy cleared", v, 32'h1);
        rd(5'd2, v); chk("R10 count zero", v, 32'h0);
        wr(5'd1, 32'h9, st);
        wr(5'd2, 32'd1, st);
        fd0 = fd_cnt;
        wr(5'd6, 32'h0, st);
        rd(5'd2, v); chk("R10 idle count zero", v, 32'h0);
        chk("R10 no pulse when idle", fd_cnt - fd0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule